// File: doc/BRIEF.md
# Free-Running Timer Counter with Prescaler

This block is the time base of a timer subsystem. A 16-bit up-counter runs without stopping and wraps from FFFFh to 0000h. It advances on one of two clock sources. The first is a prescaled copy of the system clock, divided by 2, 4 or 8. The second is an external clock input, brought into the system-clock domain by a synchronizer, that counts on a selectable edge. Capture and compare units elsewhere attach to three exported signals: the count, a one-cycle strobe marking each step, and a one-cycle pulse marking each wrap.

Software reaches the block through a byte-wide register port. There are two read-only views of the count: a normal one and an alternate one. Reading a high byte freezes the matching low byte, so a 16-bit value read as two bytes stays coherent. Writing either low-byte register loads the preset FFFCh and restarts the prescaler. A wrap sets a sticky overflow flag. The flag can raise an interrupt when enabled. Software clears it with a status read followed by a read of the normal low byte. Reads of the alternate view never clear it.

Top module: `frt_timer`

## Requirements
- R1: After reset, `count_o` is 0000h, the control register (address 4) reads 00h, the status register (address 5) reads 00h, and `irq_o` is 0.
- R2: When control bits [1:0] hold 0, 1 or 2, the count advances by one every 2, 4 or 8 system-clock cycles respectively, and wraps from FFFFh to 0000h.
- R3: Writing any data to address 1 or address 3 loads the count with FFFCh and restarts the prescaler. The first step after the write comes one full division period later.
- R4: Address 0 and address 2 return the count high byte. Address 1 and address 3 return the low byte. A high-byte read latches the low byte of the same count value, and the next low-byte read through either view returns that latched byte.
- R5: On each wrap, `ovf_pulse_o` is high for the one cycle whose closing edge wraps the count, and status bit 7 is 1 from the next cycle onward.
- R6: The overflow flag clears only when a status read that sees the flag set is followed, as the very next register access, by a read of address 1. A read of address 3, or any other access in between, leaves it set. An overflow on the clearing cycle keeps it set.
- R7: `irq_o` is high exactly while the overflow flag is set and control bit 3 (interrupt enable) is 1.
- R8: With control bits [1:0] = 3, the count advances once for each rising edge of `ext_clk_i` when control bit 2 is 0, or once for each falling edge when it is 1. The step lands three system-clock cycles after the input changes.
- R9: `count_o` always shows the live count. `count_en_o` is high exactly in the cycles at whose closing edge the count advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 3 | Register address |
| reg_rd_i | input | 1 | Read strobe, one cycle per access |
| reg_wr_i | input | 1 | Write strobe, one cycle per access |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register, same cycle |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| count_o | output | 16 | Live count value |
| count_en_o | output | 1 | Count step strobe |
| ovf_pulse_o | output | 1 | One-cycle wrap pulse |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench times the first step after a preset write at each division ratio. A design that failed to restart the prescaler would step early, and one that loaded zero would read back the wrong value. It reads high and low bytes across a low-byte rollover, so a missing latch returns a torn value. It also walks several access sequences around the overflow flag: an alternate-view read, an intervening control read, and the correct pair. A design that cleared on the wrong sequence would show status 00h where 80h is due, or the reverse. External-clock runs end on an unpaired edge, so counting the wrong polarity, or counting both edges, gives a count off by one or more.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam logic [2:0] ADDR_CNT_HI  = 3'd0;
  localparam logic [2:0] ADDR_CNT_LO  = 3'd1;
  localparam logic [2:0] ADDR_ALT_HI  = 3'd2;
  localparam logic [2:0] ADDR_ALT_LO  = 3'd3;
  localparam logic [2:0] ADDR_CTRL    = 3'd4;
  localparam logic [2:0] ADDR_STATUS  = 3'd5;

  localparam logic [1:0] CLK_EXT = 2'd3;

  typedef struct packed {
    logic [3:0] spare;
    logic       irq_en;
    logic       ext_fall;
    logic [1:0] clk_sel;
  } ctrl_t;
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
  parameter int unsigned DIV_MAX = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int unsigned PRE_W = $clog2(DIV_MAX);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    case (sel_i)
      2'd0:    limit = PRE_W'(1);
      2'd1:    limit = PRE_W'(3);
      default: limit = PRE_W'(DIV_MAX - 1);
    endcase
  end

  // >= keeps a shrinking ratio from running the full range once
  assign tick_o = en_i && !restart_i && (pre_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pre_q <= '0;
    else if (restart_i || !en_i || tick_o) pre_q <= '0;
    else                                  pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/frt_ext_edge.sv
module frt_ext_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic en_i,
  input  logic fall_i,
  output logic tick_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
      prev_q <= synced;
    end
  end

  assign tick_o = en_i && (fall_i ? (prev_q && !synced) : (!prev_q && synced));
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRESET = 'hFFFC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= CNT_W'(PRESET);
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;
  assign wrap_o  = tick_i && !load_i && (cnt_q == '1);
endmodule

// File: rtl/frt_timer.sv
module frt_timer
  import frt_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DIV_MAX     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRESET      = 'hFFFC
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          reg_addr_i,
  input  logic                reg_rd_i,
  input  logic                reg_wr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                ext_clk_i,
  output logic [2*DATA_W-1:0] count_o,
  output logic                count_en_o,
  output logic                ovf_pulse_o,
  output logic                irq_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  ctrl_t             ctrl_q;
  logic              ovf_flag_q;
  logic              clr_arm_q;
  logic [DATA_W-1:0] shadow_q;
  logic              shadow_vld_q;
  logic [CNT_W-1:0]  cnt;
  logic              pre_tick, ext_tick, tick, wrap;
  logic              ext_mode, cnt_wr, ctrl_wr, hi_rd, lo_rd, stat_rd, access;
  logic [DATA_W-1:0] lo_view;

  assign ext_mode = (ctrl_q.clk_sel == CLK_EXT);
  assign cnt_wr   = reg_wr_i && (reg_addr_i == ADDR_CNT_LO || reg_addr_i == ADDR_ALT_LO);
  assign ctrl_wr  = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign hi_rd    = reg_rd_i && (reg_addr_i == ADDR_CNT_HI || reg_addr_i == ADDR_ALT_HI);
  assign lo_rd    = reg_rd_i && (reg_addr_i == ADDR_CNT_LO || reg_addr_i == ADDR_ALT_LO);
  assign stat_rd  = reg_rd_i && (reg_addr_i == ADDR_STATUS);
  assign access   = reg_rd_i || reg_wr_i;

  frt_prescaler #(.DIV_MAX(DIV_MAX)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (!ext_mode),
    .restart_i (cnt_wr),
    .sel_i     (ctrl_q.clk_sel),
    .tick_o    (pre_tick)
  );

  frt_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_clk_i),
    .en_i   (ext_mode),
    .fall_i (ctrl_q.ext_fall),
    .tick_o (ext_tick)
  );

  assign tick = (pre_tick || ext_tick) && !cnt_wr;

  frt_counter #(.CNT_W(CNT_W), .PRESET(PRESET)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .load_i  (cnt_wr),
    .count_o (cnt),
    .wrap_o  (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata_i);
  end

  // coherent two-byte read: high read freezes low byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q     <= '0;
      shadow_vld_q <= 1'b0;
    end else if (hi_rd) begin
      shadow_q     <= cnt[DATA_W-1:0];
      shadow_vld_q <= 1'b1;
    end else if (lo_rd || cnt_wr) begin
      shadow_vld_q <= 1'b0;
    end
  end

  assign lo_view = shadow_vld_q ? shadow_q : cnt[DATA_W-1:0];

  // clear sequence: status read seeing flag, then normal low read as next access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_flag_q <= 1'b0;
      clr_arm_q  <= 1'b0;
    end else begin
      if (wrap) begin
        ovf_flag_q <= 1'b1;
        clr_arm_q  <= 1'b0;
      end else begin
        if (reg_rd_i && reg_addr_i == ADDR_CNT_LO && clr_arm_q) ovf_flag_q <= 1'b0;
        if (access) clr_arm_q <= stat_rd && ovf_flag_q;
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_CNT_HI, ADDR_ALT_HI: reg_rdata_o = cnt[CNT_W-1:DATA_W];
      ADDR_CNT_LO, ADDR_ALT_LO: reg_rdata_o = lo_view;
      ADDR_CTRL:                reg_rdata_o = DATA_W'(ctrl_q);
      ADDR_STATUS:              reg_rdata_o = {ovf_flag_q, {(DATA_W-1){1'b0}}};
      default:                  reg_rdata_o = '0;
    endcase
  end

  assign count_o     = cnt;
  assign count_en_o  = tick;
  assign ovf_pulse_o = wrap;
  assign irq_o       = ovf_flag_q && ctrl_q.irq_en;
endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRESET = 'hFFFC
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       reg_addr_i,
  input logic             reg_rd_i,
  input logic             reg_wr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             count_en_o,
  input logic             ovf_pulse_o,
  input logic             irq_o,
  input logic             flag_i
);
  logic cnt_wr;
  assign cnt_wr = reg_wr_i && (reg_addr_i == 3'd1 || reg_addr_i == 3'd3);

  p_preset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (count_o == CNT_W'(PRESET)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en_o && !cnt_wr) |=> $stable(count_o));

  p_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_o && !cnt_wr) |=> (count_o == $past(count_o) + CNT_W'(1)));

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_o && !cnt_wr && count_o == '1) |=> (count_o == '0));

  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse_o |=> flag_i);

  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_i) |-> $past(reg_rd_i && reg_addr_i == 3'd1));

  p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ovf_pulse_o || (reg_wr_i && reg_addr_i == 3'd4)));
endmodule

bind frt_timer frt_timer_chk #(.CNT_W(CNT_W), .PRESET(PRESET)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wr_i    (reg_wr_i),
  .count_o     (count_o),
  .count_en_o  (count_en_o),
  .ovf_pulse_o (ovf_pulse_o),
  .irq_o       (irq_o),
  .flag_i      (ovf_flag_q)
);

// File: tb/frt_timer_tb.sv
`timescale 1ns/1ps
module frt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ext = 1'b0;
  logic [15:0] count;
  logic        cen, ovf, irq;

  int compared = 0, mismatched = 0;
  int cyc = 0, wcyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frt_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ext_clk_i(ext), .count_o(count),
    .count_en_o(cen), .ovf_pulse_o(ovf), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a == 3'd1 || a == 3'd3) wcyc = cyc;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d, output int at);
    addr = a; rd = 1'b1;
    #1; d = rdata; at = cyc;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int div_of(input int sel);
    return 2 << sel;
  endfunction

  function automatic int exp_count(input int at, input int sel);
    return (16'hFFFC + (at - wcyc) / div_of(sel)) & 16'hFFFF;
  endfunction

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      ext = 1'b1; idle(6);
      ext = 1'b0; idle(6);
    end
    ext = 1'b1; idle(6);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d, hi, lo;
    int at, t2, sel, n;
    void'($urandom(32'h1F2E3D4C));

    idle(3);
    rst_n = 1'b1;
    chk("R1 count", count, 0);
    chk("R1 irq", irq, 0);
    reg_read(3'd4, d, at); chk("R1 ctrl", d, 8'h00);
    reg_read(3'd5, d, at); chk("R1 status", d, 8'h00);

    // div2, preset, step timing and wrap pulse
    reg_write(3'd4, 8'h08);
    reg_write(3'd1, 8'h5A);
    chk("R3 preset", count, 16'hFFFC);
    chk("R9 no step", cen, 0);
    idle(1);
    chk("R9 step strobe", cen, 1);
    idle(5);
    chk("R5 no pulse early", ovf, 0);
    idle(1);
    chk("R5 wrap pulse", ovf, 1);
    chk("R2 at FFFF", count, 16'hFFFF);
    idle(1);
    chk("R2 wrapped", count, 0);
    chk("R7 irq on", irq, 1);

    // clear sequences
    reg_read(3'd5, d, at); chk("R5 flag set", d, 8'h80);
    reg_read(3'd3, d, at);
    reg_read(3'd5, d, at); chk("R6 alt read keeps flag", d, 8'h80);
    reg_read(3'd4, d, at);
    reg_read(3'd1, d, at);
    reg_read(3'd5, d, at); chk("R6 intervening access keeps flag", d, 8'h80);
    reg_read(3'd1, d, at);
    reg_read(3'd5, d, at); chk("R6 flag cleared", d, 8'h00);
    chk("R7 irq off", irq, 0);

    // masked interrupt
    reg_write(3'd4, 8'h00);
    reg_write(3'd3, 8'h00);
    idle(12);
    reg_read(3'd5, d, at); chk("R5 flag alt preset", d, 8'h80);
    chk("R7 masked", irq, 0);

    // coherent read across low-byte rollover: count FFFF while tick pending
    reg_write(3'd1, 8'h00);
    idle(6);
    reg_read(3'd0, hi, at);
    reg_read(3'd1, lo, t2);
    chk("R4 hi at rollover", hi, 8'hFF);
    chk("R4 lo latched", lo, 8'hFF);
    chk("R2 live after", count, 16'h0000);

    // random division and views
    for (int it = 0; it < 40; it++) begin
      sel = $urandom_range(2, 0);
      n = $urandom_range(300, 0);
      reg_write(3'd4, 8'(sel));
      reg_write(($urandom_range(1, 0) != 0) ? 3'd3 : 3'd1, 8'($urandom));
      idle(n);
      reg_read(($urandom_range(1, 0) != 0) ? 3'd2 : 3'd0, hi, at);
      reg_read(($urandom_range(1, 0) != 0) ? 3'd3 : 3'd1, lo, t2);
      chk("R2 R4 random count", {hi, lo}, exp_count(at, sel));
    end

    // external clock, rising edge
    reg_write(3'd4, 8'h03);
    ext = 1'b0; idle(6);
    reg_write(3'd1, 8'h00);
    pulses(5);
    reg_read(3'd0, hi, at); reg_read(3'd1, lo, t2);
    chk("R8 rising edges", {hi, lo}, 16'h0002);

    // external clock, falling edge
    reg_write(3'd4, 8'h07);
    ext = 1'b0; idle(6);
    reg_write(3'd1, 8'h00);
    pulses(5);
    reg_read(3'd2, hi, at); reg_read(3'd3, lo, t2);
    chk("R8 falling edges", {hi, lo}, 16'h0001);

    // ext latency: change then three cycles to step
    ext = 1'b0;
    idle(2);
    chk("R8 not yet", count, 16'h0001);
    idle(1);
    chk("R8 step after sync", count, 16'h0002);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule